// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Sync Generator

This block turns a fast system clock into the two timing signals a synchronous audio serial port needs: a bit clock and a frame-sync pulse. A packed configuration word sets the clock divider, the frame length in bit clocks and the sync pulse width in bit clocks. A mode bit selects whether frames repeat on their own or start only when a data word is written. The clock generator and the frame-sync output each have their own enable. Each output has its own polarity control. A one-cycle `frame_start` strobe in the system-clock domain marks the first input cycle of every frame, so a serializer elsewhere can align to it.

All outputs are registered. A value seen on the pins reflects the inputs sampled at the previous rising edge. No data path crosses the block. `data_wr` is a plain one-cycle strobe with no back-pressure. The block always accepts it, and a write that arrives while a frame is still pending merges with that pending request.

Configuration word layout (`cfg_word`, default widths): bits 7:0 divider D, bits 15:8 sync width W, bits 27:16 frame length L, bit 28 mode (1 = free-running frames, 0 = one frame per write). All three numeric fields hold the value minus one.

Top module: `audsync_gen`

## Requirements
- R1: While `clk_en` is low, `bclk_out` equals `bclk_inv`, `fsync_out` equals `fsync_inv` and `frame_start` is 0, all as sampled at the previous edge. Right after reset all three outputs are 0.
- R2: In free-running mode (bit 28 = 1), the first output cycle after the edge that first samples `clk_en` high is input cycle 0 of bit 0 of a frame. In that cycle `frame_start` is 1 and the sync is active.
- R3: One bit clock lasts D+1 input cycles. Within it, the uninverted bit clock is low for floor((D+1)/2) cycles and then high for the rest.
- R4: A frame lasts L+1 bit clocks, with L taken from bits 27:16.
- R5: The sync is active for bits 0 through W of each frame, with W taken from bits 15:8. That is W+1 bit clocks, starting at the first bit.
- R6: `frame_start` is high for exactly the first input cycle of each frame and low at all other times.
- R7: When `sync_en` is low, `fsync_out` stays at its inactive level (`fsync_inv`). `bclk_out` and `frame_start` are not affected.
- R8: `bclk_inv` = 1 inverts the bit clock and `fsync_inv` = 1 makes the sync active low. Each takes effect on the next output cycle, and neither changes `frame_start`.
- R9: A change to D, W, L or the mode while the generator runs is applied only at the next frame boundary. The frame in progress finishes with the old values.
- R10: In write-triggered mode (bit 28 = 0), no frame runs until `data_wr` is sampled high. The frame then starts at the first bit boundary after the write has been registered, runs once, and the generator returns to idle with the sync inactive.
- R11: In write-triggered mode, a `data_wr` that arrives during a frame queues one follow-on frame. That frame starts on the cycle right after the current frame ends.
- R12: In free-running mode, `data_wr` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Releases the clock generator; low holds all counters at zero |
| sync_en | input | 1 | Releases the frame-sync output |
| cfg_word | input | 29 | Divider, sync width, frame length and mode fields |
| data_wr | input | 1 | Data-write strobe that triggers a frame in write-triggered mode |
| bclk_inv | input | 1 | Bit-clock polarity select |
| fsync_inv | input | 1 | Frame-sync polarity select (1 = active low) |
| bclk_out | output | 1 | Divided bit clock |
| fsync_out | output | 1 | Frame-sync pulse |
| frame_start | output | 1 | One-cycle strobe at the first input cycle of each frame |

## Verification
Every output is due exactly one system-clock edge after the inputs that produce it are sampled. The bench therefore drives on the falling edge and, for each rising edge, queues the output triple it expects just after that edge. The monitor compares the queue head 2 ns after each rising edge. A configuration change made mid-frame is expected to appear in the cycle after the frame's last input cycle, not earlier. A write in write-triggered mode is expected to start a frame two edges later when the write lands mid-bit: one edge to register the request and one at the bit boundary.

// File: rtl/audsync_pkg.sv
package audsync_pkg;

  // Frame launch policy selected by the mode bit of the configuration word.
  typedef enum logic {
    SYNC_ON_WRITE = 1'b0,
    SYNC_PERIODIC = 1'b1
  } sync_mode_e;

  // Output lanes that share the polarity/register structure.
  localparam int NUM_LANES  = 2;
  localparam int LANE_BCLK  = 0;
  localparam int LANE_FSYNC = 1;

endpackage

// File: rtl/audsync_clk_div.sv
module audsync_clk_div
  import audsync_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [DIV_W-1:0] div_lim,
  output logic             run_q,
  output logic [DIV_W-1:0] nxt_cnt,
  output logic             bit_end
);

  logic [DIV_W-1:0] cnt_q;

  always_comb begin
    bit_end = run_q && clk_en && (cnt_q == div_lim);
    if (!clk_en || !run_q) begin
      nxt_cnt = '0;
    end else if (cnt_q == div_lim) begin
      nxt_cnt = '0;
    end else begin
      nxt_cnt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= clk_en;
      cnt_q <= nxt_cnt;
    end
  end

endmodule

// File: rtl/audsync_cfg_shadow.sv
module audsync_cfg_shadow
  import audsync_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int WID_W = 8,
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic [WID_W-1:0] wid_in,
  input  logic [PER_W-1:0] per_in,
  input  sync_mode_e       mode_in,
  output logic [DIV_W-1:0] cur_div,
  output logic [PER_W-1:0] cur_per,
  output sync_mode_e       cur_mode,
  output logic [DIV_W-1:0] nxt_div,
  output logic [WID_W-1:0] nxt_wid,
  output sync_mode_e       nxt_mode
);

  logic [WID_W-1:0] cur_wid;
  logic [PER_W-1:0] nxt_per;

  // Shadow copy: reloads while stopped and at frame boundaries only.
  always_comb begin
    if (load) begin
      nxt_div  = div_in;
      nxt_wid  = wid_in;
      nxt_per  = per_in;
      nxt_mode = mode_in;
    end else begin
      nxt_div  = cur_div;
      nxt_wid  = cur_wid;
      nxt_per  = cur_per;
      nxt_mode = cur_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_div  <= '0;
      cur_wid  <= '0;
      cur_per  <= '0;
      cur_mode <= SYNC_ON_WRITE;
    end else begin
      cur_div  <= nxt_div;
      cur_wid  <= nxt_wid;
      cur_per  <= nxt_per;
      cur_mode <= nxt_mode;
    end
  end

endmodule

// File: rtl/audsync_frame_seq.sv
module audsync_frame_seq
  import audsync_pkg::*;
#(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             run_q,
  input  logic             bit_end,
  input  logic [PER_W-1:0] per_cur,
  input  sync_mode_e       mode_cur,
  input  sync_mode_e       mode_nxt,
  input  logic             data_wr,
  output logic             load_cfg,
  output logic [PER_W-1:0] nxt_bit,
  output logic             nxt_live
);

  logic [PER_W-1:0] bit_q;
  logic             live_q;
  logic             pend_q;
  logic             nxt_pend;
  logic             boundary;

  always_comb begin
    // A boundary is the end of a live frame's last bit, or any bit end while idle.
    boundary = bit_end && (!live_q || (bit_q == per_cur));
    load_cfg = !run_q || boundary;
    nxt_bit  = bit_q;
    nxt_live = live_q;
    nxt_pend = pend_q;
    if (!clk_en) begin
      nxt_bit  = '0;
      nxt_live = 1'b0;
      nxt_pend = 1'b0;
    end else if (!run_q) begin
      nxt_bit  = '0;
      nxt_live = (mode_nxt == SYNC_PERIODIC);
      nxt_pend = 1'b0;
    end else begin
      nxt_pend = (pend_q && !boundary) || (data_wr && (mode_cur == SYNC_ON_WRITE));
      if (boundary) begin
        nxt_bit  = '0;
        nxt_live = (mode_nxt == SYNC_PERIODIC) || pend_q;
      end else if (bit_end) begin
        nxt_bit = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      live_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      bit_q  <= nxt_bit;
      live_q <= nxt_live;
      pend_q <= nxt_pend;
    end
  end

endmodule

// File: rtl/audsync_out_stage.sv
module audsync_out_stage
  import audsync_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int WID_W = 8,
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nxt_run,
  input  logic [DIV_W-1:0] nxt_cnt,
  input  logic [DIV_W-1:0] nxt_div,
  input  logic [PER_W-1:0] nxt_bit,
  input  logic             nxt_live,
  input  logic [WID_W-1:0] nxt_wid,
  input  logic             sync_en,
  input  logic             bclk_inv,
  input  logic             fsync_inv,
  output logic             bclk_out,
  output logic             fsync_out,
  output logic             frame_start
);

  logic [NUM_LANES-1:0] lvl;
  logic [NUM_LANES-1:0] inv;
  logic [NUM_LANES-1:0] lane_out;
  logic                 strobe;
  logic                 strobe_q;

  always_comb begin
    lvl[LANE_BCLK]  = nxt_run && (int'(nxt_cnt) >= ((int'(nxt_div) + 1) / 2));
    lvl[LANE_FSYNC] = nxt_run && nxt_live && sync_en && (int'(nxt_bit) <= int'(nxt_wid));
    inv[LANE_BCLK]  = bclk_inv;
    inv[LANE_FSYNC] = fsync_inv;
    strobe          = nxt_run && nxt_live && (nxt_bit == '0) && (nxt_cnt == '0);
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= 1'b0;
      else        lane_q <= lvl[g] ^ inv[g];
    end
    assign lane_out[g] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign bclk_out    = lane_out[LANE_BCLK];
  assign fsync_out   = lane_out[LANE_FSYNC];
  assign frame_start = strobe_q;

endmodule

// File: rtl/audsync_gen.sv
module audsync_gen
  import audsync_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int WID_W = 8,
  parameter int PER_W = 12,
  localparam int CFG_W = DIV_W + WID_W + PER_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             sync_en,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             data_wr,
  input  logic             bclk_inv,
  input  logic             fsync_inv,
  output logic             bclk_out,
  output logic             fsync_out,
  output logic             frame_start
);

  localparam int WID_LSB  = DIV_W;
  localparam int PER_LSB  = DIV_W + WID_W;
  localparam int MODE_BIT = PER_LSB + PER_W;

  logic [DIV_W-1:0] raw_div, cur_div, nxt_div, nxt_cnt;
  logic [WID_W-1:0] raw_wid, nxt_wid;
  logic [PER_W-1:0] raw_per, cur_per, nxt_bit;
  sync_mode_e       raw_mode, cur_mode, nxt_mode;
  logic             run_q, bit_end, load_cfg, nxt_live;

  assign raw_div  = cfg_word[DIV_W-1:0];
  assign raw_wid  = cfg_word[PER_LSB-1:WID_LSB];
  assign raw_per  = cfg_word[MODE_BIT-1:PER_LSB];
  assign raw_mode = sync_mode_e'(cfg_word[MODE_BIT]);

  audsync_cfg_shadow #(.DIV_W(DIV_W), .WID_W(WID_W), .PER_W(PER_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_cfg),
    .div_in   (raw_div),
    .wid_in   (raw_wid),
    .per_in   (raw_per),
    .mode_in  (raw_mode),
    .cur_div  (cur_div),
    .cur_per  (cur_per),
    .cur_mode (cur_mode),
    .nxt_div  (nxt_div),
    .nxt_wid  (nxt_wid),
    .nxt_mode (nxt_mode)
  );

  audsync_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .div_lim (cur_div),
    .run_q   (run_q),
    .nxt_cnt (nxt_cnt),
    .bit_end (bit_end)
  );

  audsync_frame_seq #(.PER_W(PER_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .run_q    (run_q),
    .bit_end  (bit_end),
    .per_cur  (cur_per),
    .mode_cur (cur_mode),
    .mode_nxt (nxt_mode),
    .data_wr  (data_wr),
    .load_cfg (load_cfg),
    .nxt_bit  (nxt_bit),
    .nxt_live (nxt_live)
  );

  audsync_out_stage #(.DIV_W(DIV_W), .WID_W(WID_W), .PER_W(PER_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .nxt_run     (clk_en),
    .nxt_cnt     (nxt_cnt),
    .nxt_div     (nxt_div),
    .nxt_bit     (nxt_bit),
    .nxt_live    (nxt_live),
    .nxt_wid     (nxt_wid),
    .sync_en     (sync_en),
    .bclk_inv    (bclk_inv),
    .fsync_inv   (fsync_inv),
    .bclk_out    (bclk_out),
    .fsync_out   (fsync_out),
    .frame_start (frame_start)
  );

endmodule

// File: rtl/audsync_gen_chk.sv
module audsync_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic clk_en,
  input logic sync_en,
  input logic bclk_inv,
  input logic fsync_inv,
  input logic bclk_out,
  input logic fsync_out,
  input logic frame_start
);

  // Set one edge after reset release so $past never reaches into reset.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> !frame_start); // R1

  AST_IDLE_BCLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(clk_en)) |-> (bclk_out == $past(bclk_inv))); // R1

  AST_STROBE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && frame_start) |-> $past(clk_en)); // R2

  AST_STROBE_WITH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && frame_start && $past(sync_en)) |-> (fsync_out != $past(fsync_inv))); // R6

  AST_SYNC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(sync_en)) |-> (fsync_out == $past(fsync_inv))); // R7

endmodule

bind audsync_gen audsync_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_en      (clk_en),
  .sync_en     (sync_en),
  .bclk_inv    (bclk_inv),
  .fsync_inv   (fsync_inv),
  .bclk_out    (bclk_out),
  .fsync_out   (fsync_out),
  .frame_start (frame_start)
);

// File: tb/audsync_gen_bench.sv
`timescale 1ns/1ps
module audsync_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b0, sync_en = 1'b0, data_wr = 1'b0;
  logic        bclk_inv = 1'b0, fsync_inv = 1'b0;
  logic [28:0] cfg_word = '0;
  logic        bclk_out, fsync_out, frame_start;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic  b;
    logic  f;
    logic  s;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  audsync_gen u_audsync_gen (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sync_en(sync_en),
    .cfg_word(cfg_word), .data_wr(data_wr), .bclk_inv(bclk_inv),
    .fsync_inv(fsync_inv), .bclk_out(bclk_out), .fsync_out(fsync_out),
    .frame_start(frame_start)
  );

  function automatic logic [28:0] mk_cfg(int dv, int wd, int pr, logic periodic);
    logic [7:0]  d = 8'(dv);
    logic [7:0]  w = 8'(wd);
    logic [11:0] p = 12'(pr);
    return {periodic, p, w, d};
  endfunction

  // Queue the outputs expected just after the coming rising edge, then advance.
  task automatic step(input logic eb, input logic ef, input logic es, input string tag);
    exp_t e;
    e.b = eb; e.f = ef; e.s = es; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compares the queue head 2 ns after each rising edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if (bclk_out !== e.b || fsync_out !== e.f || frame_start !== e.s) begin
          failures++;
          $display("FAIL %s: got bclk=%0b fsync=%0b fstart=%0b exp bclk=%0b fsync=%0b fstart=%0b",
                   e.tag, bclk_out, fsync_out, frame_start, e.b, e.f, e.s);
        end
      end
    end
  end

  task automatic idle(input int n, input string tag);
    clk_en = 1'b0;
    data_wr = 1'b0;
    for (int i = 0; i < n; i++) step(bclk_inv, fsync_inv, 1'b0, tag);
  endtask

  // Free-running frames: P input cycles per bit, F bits per frame, sync on bits 0..W.
  task automatic run_periodic(input int k0, input int n, input int p, input int f, input int w,
                              input int wr_at, input string tag);
    for (int k = k0; k < k0 + n; k++) begin
      logic eb, ef, es;
      clk_en  = 1'b1;
      data_wr = (k == wr_at);
      eb = ((k % p) >= (p / 2)) ^ bclk_inv;
      ef = (sync_en && (((k / p) % f) <= w)) ^ fsync_inv;
      es = ((k % (p * f)) == 0);
      step(eb, ef, es, tag);
    end
    data_wr = 1'b0;
  endtask

  task automatic chk_now(input logic cond, input string tag);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s: got bclk=%0b fsync=%0b fstart=%0b exp 0 0 0",
               tag, bclk_out, fsync_out, frame_start);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_now(bclk_out == 1'b0 && fsync_out == 1'b0 && frame_start == 1'b0, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: stopped generator shows idle levels, following polarity.
    idle(3, "R1 idle");
    bclk_inv = 1'b1; fsync_inv = 1'b1;
    idle(3, "R1 R8 idle inverted");
    bclk_inv = 1'b0; fsync_inv = 1'b0;
    idle(2, "R1 idle");

    // R2 R3 R4 R5 R6 R12: divider 4, 8-bit frame, 2-bit sync; write pulse ignored.
    sync_en  = 1'b1;
    cfg_word = mk_cfg(3, 1, 7, 1'b1);
    run_periodic(0, 64, 4, 8, 1, 20, "R2 R3 R4 R5 R6 R12 periodic");
    idle(2, "R1 stop");

    // R3 R4 R5: symmetric stereo, 16-bit words, divide by 2.
    cfg_word = mk_cfg(1, 15, 31, 1'b1);
    run_periodic(0, 128, 2, 32, 15, -1, "R3 R4 R5 stereo");
    idle(2, "R1 stop");

    // R8: both polarities inverted.
    bclk_inv = 1'b1; fsync_inv = 1'b1;
    cfg_word = mk_cfg(3, 1, 7, 1'b1);
    run_periodic(0, 32, 4, 8, 1, -1, "R8 inverted");
    idle(2, "R1 R8 stop inverted");
    bclk_inv = 1'b0; fsync_inv = 1'b0;
    idle(1, "R1 stop");

    // R7: sync disabled, bit clock and strobe continue.
    sync_en = 1'b0;
    run_periodic(0, 32, 4, 8, 1, -1, "R7 sync off");
    sync_en = 1'b1;
    idle(2, "R1 stop");

    // R9: divider and period changed mid-frame apply at the next boundary.
    cfg_word = mk_cfg(3, 1, 7, 1'b1);
    run_periodic(0, 40, 4, 8, 1, -1, "R9 before change");
    cfg_word = mk_cfg(1, 1, 3, 1'b1);
    run_periodic(40, 24, 4, 8, 1, -1, "R9 old frame kept");
    run_periodic(0, 32, 2, 4, 1, -1, "R9 new settings");
    idle(2, "R1 stop");

    // R10 R11: write-triggered frames, divide by 2, 4-bit frame, 1-bit sync.
    cfg_word = mk_cfg(1, 0, 3, 1'b0);
    for (int m = 0; m < 28; m++) begin
      logic ef, es;
      int st;
      clk_en  = 1'b1;
      data_wr = (m == 3) || (m == 7);
      st = (m >= 12 && m < 20) ? 12 : ((m >= 4 && m < 12) ? 4 : -1);
      ef = (st >= 0) && ((m - st) < 2);
      es = (m == 4) || (m == 12);
      step((m % 2) == 1, ef, es, (m >= 12) ? "R11 queued frame" : "R10 triggered frame");
    end
    data_wr = 1'b0;
    idle(3, "R1 stop");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule